// File: doc/BRIEF.md
# Transmit Start-Threshold FIFO

This block is a byte-wide transmit buffer placed between a host-side writer (normally a DMA engine) and a MAC-side reader. Frame bytes enter with an end-of-frame marker. The block decides when the MAC may begin sending the frame at its head. The rule is either a programmable byte count for early start or, in full-packet mode, the presence of the whole frame. It also keeps the opening bytes of the frame in transit for a possible collision retry, and it requests refills from the DMA engine whenever enough free space is available.

Both data edges use valid/ready. On the write side, a byte transfers on a clock edge where `wr_valid` and `wr_ready` are both high. When `wr_ready` is low the writer must hold its byte and marker steady, and nothing is stored. On the read side, a byte is consumed on an edge where `rd_valid` and `rd_ready` are both high. The MAC may hold `rd_ready` low for any length of time without losing data. `tx_start` stays high from the moment a frame is released until the MAC reports it done, or until a retry rewinds it. `mac_coll` and `mac_done` are single-cycle strobes from the MAC.

A collision during the protected opening window rewinds the reader to the first byte of the frame, and the frame is then offered again. A collision after that window is flagged as a late collision. In full-duplex operation, or when retries are disabled, no bytes are held back and collisions are ignored. The default depth is 256 bytes.

Top module: `tx_start_fifo`

## Requirements
- R1: The 2-bit start setting selects the early-start byte count: 00 = 20, 01 = 64, 10 = 128, 11 = 220. `tx_start` rises one cycle after the write that brings the head frame's stored byte count to that value, and not before.
- R2: A head frame whose end-of-frame marker has been stored is released one cycle after that write, whatever the start setting.
- R3: With `full_pkt_mode` high, `tx_start` stays low until the head frame's end-of-frame byte is stored, whatever its byte count.
- R4: Reset (`rst_n` low or `soft_rst` high) returns the start setting to 01. `cfg_we` changes the start setting and the watermark setting only while `cfg_halt` is high. Holding `cfg_halt` changes neither setting.
- R5: `rd_valid` is high only while `tx_start` is high. Bytes leave in write order, and `rd_last` is high on the end-of-frame byte only. After that byte is read, `rd_valid` stays low until the frame is finished.
- R6: In half-duplex with retries enabled, the space of the frame being sent is not returned until 64 of its bytes have been read, or until `mac_done` if the frame is shorter than 64 bytes.
- R7: With `full_duplex` or `retry_dis` high, each byte's space is returned as soon as that byte is read.
- R8: In the protected window (R6 conditions, fewer than 64 bytes read), `mac_coll` drops `tx_start` for one cycle. The reader then restarts at the frame's first byte, and `late_coll` stays low.
- R9: In half-duplex with retries enabled, `mac_coll` after 64 bytes have been read raises `late_coll` for one cycle and does not rewind the reader. With `full_duplex` high, `mac_coll` has no effect.
- R10: When the stored bytes plus the held-back bytes fill the depth, `wr_ready` is low and an offered byte is neither stored nor counted.
- R11: `dma_req` is high exactly when free space, not counting held-back bytes, is at least the watermark. Watermark encoding: 00 = 16, 01 = 32, 10 = 64, 11 = 64. Reset value is 00.
- R12: `mac_done` after the end-of-frame byte has been read drops `tx_start` one cycle later, returns all of the frame's space, and moves the head to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset: empties the buffer and restores the settings |
| cfg_halt | input | 1 | Stop or suspend is active; enables setting writes |
| cfg_we | input | 1 | Setting write strobe |
| cfg_start_sel | input | 2 | Start setting to write |
| cfg_wm_sel | input | 2 | Watermark setting to write |
| full_pkt_mode | input | 1 | Release only complete frames |
| full_duplex | input | 1 | Full-duplex link; no retry protection |
| retry_dis | input | 1 | Retries disabled; no retry protection |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Space is available for a byte |
| wr_data | input | DW | Write byte |
| wr_last | input | 1 | Write byte ends the frame |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | MAC takes the byte |
| rd_data | output | DW | Read byte |
| rd_last | output | 1 | Read byte ends the frame |
| tx_start | output | 1 | Head frame is released for transmission |
| mac_coll | input | 1 | Collision strobe |
| mac_done | input | 1 | Frame-finished strobe |
| late_coll | output | 1 | Collision after the protected window |
| dma_req | output | 1 | Free space reaches the watermark |

## Verification
The checker relies on the MAC keeping to its protocol. `mac_done` arrives only after the end-of-frame byte has been read. Neither strobe shares a cycle with a read handshake. The settings are written only while no frame is being sent. The bench keeps to these rules by issuing every strobe with `rd_ready` already low, finishing frames only once they are drained, and writing settings only right after a software reset. It sweeps all four start settings and all four watermark encodings at their exact boundaries, in both protected and unprotected modes.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_DRAIN = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic full_pkt;
    logic full_dup;
    logic no_retry;
  } tx_mode_t;

  function automatic int unsigned start_point_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 20;
      2'b01:   return 64;
      2'b10:   return 128;
      default: return 220;
    endcase
  endfunction

  function automatic int unsigned watermark_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 16;
      2'b01:   return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/tsf_cfg.sv
module tsf_cfg #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          halt,
  input  logic          we,
  input  logic [1:0]    start_sel_i,
  input  logic [1:0]    wm_sel_i,
  output logic [CW-1:0] thr_o,
  output logic [CW-1:0] wm_o
);
  import tsf_pkg::*;

  localparam logic [1:0] START_RST = 2'b01;
  localparam logic [1:0] WM_RST    = 2'b00;

  logic [1:0] start_q;
  logic [1:0] wm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= START_RST;
      wm_q    <= WM_RST;
    end else if (soft_rst) begin
      start_q <= START_RST;
      wm_q    <= WM_RST;
    end else if (we && halt) begin
      start_q <= start_sel_i;
      wm_q    <= wm_sel_i;
    end
  end

  always_comb begin
    thr_o = CW'(start_point_bytes(start_q));
    wm_o  = CW'(watermark_bytes(wm_q));
  end

endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW:0]   rdata
);
  logic [DW:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl #(
  parameter int DEPTH = 256,
  parameter int WIN   = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  tsf_pkg::tx_mode_t mode,
  input  logic [PW-1:0]   thr,
  input  logic [PW-1:0]   wm,
  input  logic            wr_valid,
  input  logic            wr_last,
  output logic            wr_ready,
  output logic            wr_fire,
  output logic [AW-1:0]   waddr,
  input  logic            rd_ready,
  input  logic            rd_last_i,
  output logic            rd_valid,
  output logic [AW-1:0]   raddr,
  input  logic            mac_coll,
  input  logic            mac_done,
  output logic            tx_start,
  output logic            late_coll,
  output logic            dma_req,
  output logic [PW-1:0]   wptr_o,
  output logic [PW-1:0]   rptr_o,
  output logic [PW-1:0]   fs_ptr_o,
  output logic [PW-1:0]   occ_o,
  output logic [PW-1:0]   eof_cnt_o
);
  import tsf_pkg::*;

  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] WIN_CNT  = PW'(WIN);

  tx_state_e     state_q;
  logic [PW-1:0] wptr_q, rptr_q, fs_q, eof_q;
  logic          late_q;

  logic [PW-1:0] sent, avail, rel, occ, free_sp;
  logic          guard, in_win, rd_fire, busy, go;
  logic          rewind, late_hit, finish, eof_inc, eof_dec;

  // Retry protection applies only in half duplex with retries allowed.
  always_comb begin
    guard    = !mode.full_dup && !mode.no_retry;
    sent     = rptr_q - fs_q;
    avail    = wptr_q - fs_q;
    in_win   = guard && (sent < WIN_CNT);
    rel      = in_win ? fs_q : rptr_q;
    occ      = wptr_q - rel;
    free_sp  = FULL_CNT - occ;
    busy     = (state_q != ST_IDLE);
    wr_ready = (occ != FULL_CNT);
    wr_fire  = wr_valid && wr_ready;
    rd_valid = (state_q == ST_SEND) && (rptr_q != wptr_q);
    rd_fire  = rd_valid && rd_ready;
    go       = (eof_q != '0) || (!mode.full_pkt && (avail >= thr));
    rewind   = mac_coll && busy && in_win;
    late_hit = mac_coll && busy && guard && !in_win;
    finish   = mac_done && (state_q == ST_DRAIN);
    eof_inc  = wr_fire && wr_last;
    eof_dec  = finish && !rewind;
    dma_req  = (free_sp >= wm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wptr_q  <= '0;
      rptr_q  <= '0;
      fs_q    <= '0;
      eof_q   <= '0;
      late_q  <= 1'b0;
    end else if (soft_rst) begin
      state_q <= ST_IDLE;
      wptr_q  <= '0;
      rptr_q  <= '0;
      fs_q    <= '0;
      eof_q   <= '0;
      late_q  <= 1'b0;
    end else begin
      late_q <= late_hit;
      if (wr_fire) wptr_q <= wptr_q + 1'b1;
      case ({eof_inc, eof_dec})
        2'b10:   eof_q <= eof_q + 1'b1;
        2'b01:   eof_q <= eof_q - 1'b1;
        default: eof_q <= eof_q;
      endcase
      if (rewind) begin
        rptr_q  <= fs_q;
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (go) state_q <= ST_SEND;
          end
          ST_SEND: begin
            if (rd_fire) begin
              rptr_q <= rptr_q + 1'b1;
              if (rd_last_i) state_q <= ST_DRAIN;
            end
          end
          ST_DRAIN: begin
            if (finish) begin
              fs_q    <= rptr_q;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign waddr     = wptr_q[AW-1:0];
  assign raddr     = rptr_q[AW-1:0];
  assign tx_start  = busy;
  assign late_coll = late_q;
  assign wptr_o    = wptr_q;
  assign rptr_o    = rptr_q;
  assign fs_ptr_o  = fs_q;
  assign occ_o     = occ;
  assign eof_cnt_o = eof_q;

endmodule

// File: rtl/tx_start_fifo.sv
module tx_start_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int WIN   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          cfg_halt,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_start_sel,
  input  logic [1:0]    cfg_wm_sel,
  input  logic          full_pkt_mode,
  input  logic          full_duplex,
  input  logic          retry_dis,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          tx_start,
  input  logic          mac_coll,
  input  logic          mac_done,
  output logic          late_coll,
  output logic          dma_req
);
  import tsf_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  tx_mode_t      mode;
  logic [PW-1:0] thr, wm;
  logic          wr_fire;
  logic [AW-1:0] waddr, raddr;
  logic [DW:0]   rdata;
  logic [PW-1:0] wptr, rptr, fs_ptr, occ, eof_cnt;

  assign mode = '{full_pkt: full_pkt_mode, full_dup: full_duplex, no_retry: retry_dis};

  tsf_cfg #(.CW(PW)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .halt        (cfg_halt),
    .we          (cfg_we),
    .start_sel_i (cfg_start_sel),
    .wm_sel_i    (cfg_wm_sel),
    .thr_o       (thr),
    .wm_o        (wm)
  );

  tsf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (waddr),
    .wdata ({wr_last, wr_data}),
    .raddr (raddr),
    .rdata (rdata)
  );

  tsf_ctrl #(.DEPTH(DEPTH), .WIN(WIN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .mode      (mode),
    .thr       (thr),
    .wm        (wm),
    .wr_valid  (wr_valid),
    .wr_last   (wr_last),
    .wr_ready  (wr_ready),
    .wr_fire   (wr_fire),
    .waddr     (waddr),
    .rd_ready  (rd_ready),
    .rd_last_i (rdata[DW]),
    .rd_valid  (rd_valid),
    .raddr     (raddr),
    .mac_coll  (mac_coll),
    .mac_done  (mac_done),
    .tx_start  (tx_start),
    .late_coll (late_coll),
    .dma_req   (dma_req),
    .wptr_o    (wptr),
    .rptr_o    (rptr),
    .fs_ptr_o  (fs_ptr),
    .occ_o     (occ),
    .eof_cnt_o (eof_cnt)
  );

  assign rd_data = rdata[DW-1:0];
  assign rd_last = rdata[DW];

endmodule

// File: rtl/tsf_chk.sv
module tsf_chk #(
  parameter int DEPTH = 256,
  parameter int WIN   = 64,
  parameter int PW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          full_pkt_mode,
  input logic          full_duplex,
  input logic          retry_dis,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          tx_start,
  input logic          mac_coll,
  input logic          late_coll,
  input logic          dma_req,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] fs_ptr,
  input logic [PW-1:0] occ,
  input logic [PW-1:0] eof_cnt
);
  logic [PW-1:0] sent_c;
  assign sent_c = rptr - fs_ptr;

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    occ <= PW'(DEPTH));

  a_r10_full_refuse: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (wr_valid && !wr_ready) |=> (wptr == $past(wptr)));

  a_r5_read_gated: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    rd_valid |-> tx_start);

  a_r3_whole_frame: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ($rose(tx_start) && $past(full_pkt_mode)) |-> (eof_cnt != '0));

  a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (mac_coll && tx_start && !full_duplex && !retry_dis && (sent_c < PW'(WIN)))
      |=> ((rptr == $past(fs_ptr)) && !tx_start && !late_coll));

  a_r9_late_source: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    late_coll |-> $past(mac_coll));

  a_r11_dma_space: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    dma_req |-> wr_ready);

endmodule

bind tx_start_fifo tsf_chk #(.DEPTH(DEPTH), .WIN(WIN), .PW(PW)) u_tsf_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .full_pkt_mode (full_pkt_mode),
  .full_duplex   (full_duplex),
  .retry_dis     (retry_dis),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .rd_valid      (rd_valid),
  .tx_start      (tx_start),
  .mac_coll      (mac_coll),
  .late_coll     (late_coll),
  .dma_req       (dma_req),
  .wptr          (wptr),
  .rptr          (rptr),
  .fs_ptr        (fs_ptr),
  .occ           (occ),
  .eof_cnt       (eof_cnt)
);

// File: tb/tx_start_fifo_bench.sv
module tx_start_fifo_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, soft_rst = 1'b0;
  logic       cfg_halt = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_start_sel = 2'b00, cfg_wm_sel = 2'b00;
  logic       full_pkt_mode = 1'b0, full_duplex = 1'b1, retry_dis = 1'b0;
  logic       wr_valid = 1'b0, wr_last = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       mac_coll = 1'b0, mac_done = 1'b0;
  logic       wr_ready, rd_valid, rd_last, tx_start, late_coll, dma_req;
  logic [7:0] rd_data;

  tx_start_fifo u_tx_start_fifo (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_halt(cfg_halt), .cfg_we(cfg_we),
    .cfg_start_sel(cfg_start_sel), .cfg_wm_sel(cfg_wm_sel),
    .full_pkt_mode(full_pkt_mode), .full_duplex(full_duplex), .retry_dis(retry_dis),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .tx_start(tx_start), .mac_coll(mac_coll), .mac_done(mac_done),
    .late_coll(late_coll), .dma_req(dma_req)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp_v);
    nchk++;
    if (act != exp_v) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 7) + 3);
  endfunction

  function automatic int thr_of(input int s);
    case (s)
      0: return 20;
      1: return 64;
      2: return 128;
      default: return 220;
    endcase
  endfunction

  function automatic int wm_of(input int s);
    case (s)
      0: return 16;
      1: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic push(input logic [7:0] d, input bit l);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_last = l;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic wr_stop();
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic fill(input int n, input int base, input bit endlast);
    for (int i = 0; i < n; i++) push(pat(base + i), endlast && (i == n - 1));
    wr_stop();
  endtask

  task automatic pop(input logic [7:0] d, input bit l, input string req);
    @(negedge clk);
    rd_ready = 1'b1;
    while (!rd_valid) @(negedge clk);
    chk(req, int'(rd_data), int'(d));
    chk(req, int'(rd_last), int'(l));
    @(posedge clk);
  endtask

  task automatic rd_stop();
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic drain(input int from, input int to, input int base, input int lastidx, input string req);
    for (int i = from; i <= to; i++) pop(pat(base + i), i == lastidx, req);
    rd_stop();
  endtask

  task automatic sreset();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic setcfg(input int s, input int w);
    @(negedge clk);
    cfg_halt = 1'b1; cfg_we = 1'b1;
    cfg_start_sel = 2'(s); cfg_wm_sel = 2'(w);
    @(negedge clk);
    cfg_we = 1'b0; cfg_halt = 1'b0;
  endtask

  task automatic pulse_coll();
    @(negedge clk); mac_coll = 1'b1;
    @(negedge clk); mac_coll = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); mac_done = 1'b1;
    @(negedge clk); mac_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R5 reset tx_start", int'(tx_start), 0);
    chk("R5 reset rd_valid", int'(rd_valid), 0);
    chk("R10 reset wr_ready", int'(wr_ready), 1);
    chk("R11 reset dma_req", int'(dma_req), 1);
    chk("R9 reset late_coll", int'(late_coll), 0);

    // R4: default 64, soft reset restores it, writes without halt ignored
    setcfg(0, 0);
    sreset();
    @(negedge clk); cfg_we = 1'b1; cfg_start_sel = 2'b00;
    @(negedge clk); cfg_we = 1'b0;
    fill(63, 0, 1'b0);
    idle(2);
    chk("R4 start default below 64", int'(tx_start), 0);
    push(pat(63), 1'b0);
    wr_stop();
    chk("R4 start default same cycle", int'(tx_start), 0);
    idle(1);
    chk("R4 start default at 64", int'(tx_start), 1);

    // R1: sweep of all start settings at the exact boundary
    for (int s = 0; s < 4; s++) begin
      sreset();
      setcfg(s, 0);
      fill(thr_of(s) - 1, 0, 1'b0);
      idle(2);
      chk("R1 below threshold", int'(tx_start), 0);
      push(pat(thr_of(s)), 1'b0);
      wr_stop();
      chk("R1 threshold edge", int'(tx_start), 0);
      idle(1);
      chk("R1 threshold reached", int'(tx_start), 1);
    end

    // R2: short complete frame overrides every setting
    for (int s = 0; s < 4; s++) begin
      sreset();
      setcfg(s, 0);
      fill(10, 0, 1'b1);
      chk("R2 complete frame edge", int'(tx_start), 0);
      idle(1);
      chk("R2 complete frame released", int'(tx_start), 1);
    end

    // R3: full-packet mode holds past the threshold
    sreset();
    setcfg(0, 0);
    full_pkt_mode = 1'b1;
    fill(219, 0, 1'b0);
    idle(2);
    chk("R3 full packet held", int'(tx_start), 0);
    push(pat(219), 1'b1);
    wr_stop();
    chk("R3 full packet edge", int'(tx_start), 0);
    idle(1);
    chk("R3 full packet released", int'(tx_start), 1);

    // R5 / R12: read order, gap after last, done and next frame
    drain(0, 219, 0, 219, "R5 read order");
    idle(3);
    chk("R5 no read after last", int'(rd_valid), 0);
    chk("R5 start held until done", int'(tx_start), 1);
    pulse_done();
    chk("R12 done drops start", int'(tx_start), 0);
    fill(30, 500, 1'b1);
    idle(1);
    chk("R12 next frame released", int'(tx_start), 1);
    drain(0, 29, 500, 29, "R12 next frame data");
    pulse_done();
    full_pkt_mode = 1'b0;

    // R11: watermark sweep at the exact boundary
    for (int w = 0; w < 4; w++) begin
      sreset();
      setcfg(1, w);
      fill(256 - wm_of(w), 0, 1'b0);
      idle(1);
      chk("R11 free equals watermark", int'(dma_req), 1);
      push(pat(0), 1'b0);
      wr_stop();
      chk("R11 free below watermark", int'(dma_req), 0);
    end
    sreset();
    @(negedge clk); cfg_we = 1'b1; cfg_wm_sel = 2'b10;
    @(negedge clk); cfg_we = 1'b0;
    fill(240, 0, 1'b0);
    chk("R11 watermark write without halt ignored", int'(dma_req), 1);
    push(pat(0), 1'b0);
    wr_stop();
    chk("R11 watermark stays 16", int'(dma_req), 0);

    // R10: full buffer refuses writes
    sreset();
    full_duplex = 1'b1;
    fill(256, 0, 1'b1);
    chk("R10 full not ready", int'(wr_ready), 0);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b0;
    idle(3);
    wr_valid = 1'b0;
    chk("R10 still not ready", int'(wr_ready), 0);
    drain(0, 255, 0, 255, "R10 contents intact");
    pulse_done();
    fill(63, 0, 1'b0);
    idle(2);
    chk("R10 refused byte not stored", int'(tx_start), 0);

    // R7: unprotected modes return space per byte
    for (int m = 0; m < 2; m++) begin
      sreset();
      full_duplex = (m == 0);
      retry_dis = (m == 1);
      setcfg(1, 2);
      fill(250, 0, 1'b0);
      chk("R7 nearly full", int'(dma_req), 0);
      drain(0, 56, 0, -1, "R7 data");
      chk("R7 one short of watermark", int'(dma_req), 0);
      drain(57, 57, 0, -1, "R7 data");
      chk("R7 space returned per byte", int'(dma_req), 1);
    end

    // R6: protected window in half duplex
    sreset();
    full_duplex = 1'b0; retry_dis = 1'b0;
    setcfg(1, 2);
    fill(250, 0, 1'b0);
    drain(0, 62, 0, -1, "R6 data");
    chk("R6 space held in window", int'(dma_req), 0);
    drain(63, 63, 0, -1, "R6 data");
    chk("R6 space returned after 64", int'(dma_req), 1);
    sreset();
    setcfg(1, 0);
    fill(30, 0, 1'b1);
    fill(210, 100, 1'b0);
    chk("R6 short frame free 16", int'(dma_req), 1);
    push(pat(0), 1'b0);
    wr_stop();
    chk("R6 short frame free 15", int'(dma_req), 0);
    drain(0, 29, 0, 29, "R6 short frame data");
    idle(1);
    chk("R6 short frame held until done", int'(dma_req), 0);
    pulse_done();
    chk("R6 short frame freed by done", int'(dma_req), 1);

    // R8 / R9: collision inside and after the window
    sreset();
    setcfg(1, 0);
    fill(100, 0, 1'b1);
    idle(1);
    chk("R8 frame released", int'(tx_start), 1);
    drain(0, 29, 0, 99, "R8 first attempt");
    pulse_coll();
    chk("R8 start dropped", int'(tx_start), 0);
    chk("R8 no late flag", int'(late_coll), 0);
    idle(1);
    chk("R8 start re-armed", int'(tx_start), 1);
    drain(0, 69, 0, 99, "R8 replay from first byte");
    pulse_coll();
    chk("R9 late flag", int'(late_coll), 1);
    chk("R9 start kept", int'(tx_start), 1);
    idle(1);
    chk("R9 late flag one cycle", int'(late_coll), 0);
    drain(70, 99, 0, 99, "R9 no rewind");
    pulse_done();

    sreset();
    full_duplex = 1'b1;
    fill(50, 0, 1'b1);
    drain(0, 19, 0, 49, "R9 full duplex data");
    pulse_coll();
    chk("R9 full duplex no late", int'(late_coll), 0);
    chk("R9 full duplex start kept", int'(tx_start), 1);
    drain(20, 49, 0, 49, "R9 full duplex ignores collision");
    pulse_done();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule